// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Start Qualification

The block recovers asynchronous 8-bit characters from one serial input line. It works from a sample tick that runs at sixteen times the bit rate, so each bit period holds sample slots 1 to 16. It waits for a low sample that follows three high samples, then takes three check samples inside the suspected start bit. A two-of-three low vote accepts the start bit. A vote with any high sample still accepts the bit but marks the character as noisy. Each data bit and the stop bit are then decided by a two-of-three vote over the middle slots of their bit periods.

To cope with a sender whose bit rate differs from the local one, the slot counter is pulled into line with the line whenever a data bit decided high is followed by a data bit decided low. The slot at which that falling edge was seen becomes slot 1. A finished character is placed on the data output with a ready flag that holds until a clear strobe arrives. An interrupt request follows the ready flag while interrupts are enabled.

Top module: `uart_rx_qual`

## Requirements
- R1: During and right after reset, rx_data is 0x00 and rx_ready, rx_noise, rx_ferr and rx_irq are all 0.
- R2: A start bit is only taken on a tick whose sample is 0 when the three previous tick samples were all 1. A falling edge that follows only two high samples starts nothing, even if the line then stays low.
- R3: Slot 1 is the tick of the qualifying low sample. The start bit is checked with the samples at slots 3, 5 and 7. It is accepted when at least two of them are 0. With patterns 011, 101, 110 or 111 (order: slot 3, slot 5, slot 7) no character is delivered and the search restarts.
- R4: The noise flag of a character is 1 when its start check pattern was 001, 010 or 100, and 0 when the pattern was 000.
- R5: Data bits follow the start bit least significant bit first, one per 16 ticks. Each bit is the majority of the samples at slots 8, 9 and 10 of its period. Eight data bits are followed by one stop bit and there is no parity.
- R6: When a data bit decides 1 and the next data bit decides 0, the slot counter is re-aligned so that the tick of that 1-to-0 line change is slot 1. Characters sent at 14 or 18 ticks per bit are therefore received correctly.
- R7: The stop bit is the majority of slots 8, 9 and 10. A 0 result sets rx_ferr, and the byte is still delivered with rx_ready.
- R8: rx_ready rises in the clock edge of the tick at stop-bit slot 10. It holds until a one-cycle clr_ready strobe. A character completing in the same cycle as the strobe leaves rx_ready at 1.
- R9: rx_irq is 1 exactly when rx_ready is 1 and irq_en is 1.
- R10: rx_data, rx_noise and rx_ferr change only when a character is delivered, and all three are then replaced with the values of that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rt_tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idle high |
| irq_en | input | 1 | Enables the interrupt request |
| clr_ready | input | 1 | One-cycle strobe that clears the ready flag |
| rx_data | output | 8 | Last received byte |
| rx_ready | output | 1 | A byte is waiting |
| rx_noise | output | 1 | Start check of the last byte was not unanimous |
| rx_ferr | output | 1 | Stop bit of the last byte was low |
| rx_irq | output | 1 | Interrupt request |

## Verification
The delivery of a new character and the clear strobe can land on the same clock edge. The bench provokes this by raising clr_ready together with the tick at stop-bit slot 10 while an earlier byte is still flagged. It judges the result by rx_ready staying 1 with the new byte on rx_data, and by a later lone strobe dropping the flag. A reference model of the ready flag, advanced by the stimulus tasks, is compared with rx_ready and rx_irq on every clock.

// File: rtl/uart_rx_pkg.sv
// Shared types and helpers for the oversampled receiver.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package uart_rx_pkg;

    // Receive phase: hunting for a start, checking it, data bits, stop bit.
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;

    // Two-of-three majority of three samples.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/uart_rx_hunt.sv
// Line watcher: keeps the last three tick samples of the line and the age
// of the most recent 1-to-0 change, counted in ticks (1 = this tick).
// Assumes: rxd is already synchronous to clk; tick is a one-cycle enable.
module uart_rx_hunt #(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    output logic             start_hit,
    output logic [AGE_W-1:0] edge_age_n
);
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    logic [2:0]       hist;
    logic [AGE_W-1:0] age;
    logic             fall;

    // Detect a qualifying start edge and the age the edge counter takes now.
    always_comb begin
        fall       = hist[0] & ~rxd;
        start_hit  = tick & (hist == 3'b111) & ~rxd;
        edge_age_n = fall ? AGE_W'(1) : ((age == AGE_MAX) ? age : age + AGE_W'(1));
    end

    // Shift in one line sample and advance the edge age on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= 3'b000;
            age  <= AGE_MAX;
        end else if (tick) begin
            hist <= {hist[1:0], rxd};
            age  <= edge_age_n;
        end
    end

    // R2: a start can only be flagged on a tick whose sample is low.
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        start_hit |-> (tick && !rxd));

endmodule

// File: rtl/uart_rx_frame.sv
// Character sequencer: counts the sixteen slots of each bit and checks the
// start bit at three slots. It votes each data and stop bit over the
// middle slots, re-aligns on 1-to-0 data changes and emits a one-cycle
// deliver pulse.
// Assumes: OSR >= 12 so that all sample slots fit in one bit period.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int AGE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic              start_hit,
    input  logic [AGE_W-1:0]  edge_age_n,
    output logic              deliver,
    output logic [DATA_W-1:0] byte_q,
    output logic              noise_q,
    output logic              ferr_q
);
    localparam int CNT_W = $clog2(OSR + 1);
    localparam int BIT_W = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] RT_V1 = CNT_W'(OSR/2 - 5);
    localparam logic [CNT_W-1:0] RT_V2 = CNT_W'(OSR/2 - 3);
    localparam logic [CNT_W-1:0] RT_V3 = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] RT_M1 = CNT_W'(OSR/2);
    localparam logic [CNT_W-1:0] RT_M2 = CNT_W'(OSR/2 + 1);
    localparam logic [CNT_W-1:0] RT_M3 = CNT_W'(OSR/2 + 2);
    localparam logic [CNT_W-1:0] RT_END = CNT_W'(OSR);

    rx_state_t         state;
    logic [CNT_W-1:0]  rt, rt_n;
    logic [BIT_W-1:0]  bitn;
    logic              s_a, s_b, vote, wrap;
    logic              decided, prev_maj, noise;
    logic [DATA_W-1:0] shreg;
    logic              realign;

    // Next slot number, bit-boundary wrap, vote and re-alignment condition.
    always_comb begin
        wrap    = (rt == RT_END);
        rt_n    = wrap ? CNT_W'(1) : rt + CNT_W'(1);
        vote    = vote3(s_a, s_b, rxd);
        realign = prev_maj && !vote && (edge_age_n < AGE_W'(OSR));
        deliver = tick && (state == ST_STOP) && (rt_n == RT_M3) && !decided;
        byte_q  = shreg;
        noise_q = noise;
        ferr_q  = ~vote;
    end

    // Slot counter, bit counter, sampling, voting and phase sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            rt       <= '0;
            bitn     <= '0;
            s_a      <= 1'b0;
            s_b      <= 1'b0;
            decided  <= 1'b0;
            prev_maj <= 1'b0;
            noise    <= 1'b0;
            shreg    <= '0;
        end else if (tick) begin
            if (state == ST_HUNT) begin
                if (start_hit) begin
                    state   <= ST_START;
                    rt      <= CNT_W'(1);
                    bitn    <= '0;
                    decided <= 1'b0;
                end
            end else begin
                rt <= rt_n;
                if (wrap) begin
                    bitn    <= bitn + BIT_W'(1);
                    decided <= 1'b0;
                    if (bitn == '0)
                        state <= ST_DATA;
                    else if (bitn == BIT_W'(DATA_W))
                        state <= ST_STOP;
                end
                if (state == ST_START) begin
                    if (rt_n == RT_V1) s_a <= rxd;
                    if (rt_n == RT_V2) s_b <= rxd;
                    if (rt_n == RT_V3) begin
                        if (!vote) begin
                            noise    <= s_a | s_b | rxd;
                            prev_maj <= 1'b0;
                        end else begin
                            state <= ST_HUNT;
                        end
                    end
                end else if (!decided) begin
                    if (rt_n == RT_M1) s_a <= rxd;
                    if (rt_n == RT_M2) s_b <= rxd;
                    if (rt_n == RT_M3) begin
                        decided <= 1'b1;
                        if (state == ST_DATA) begin
                            shreg    <= {vote, shreg[DATA_W-1:1]};
                            prev_maj <= vote;
                            if (realign) rt <= CNT_W'(edge_age_n);
                        end else begin
                            state <= ST_HUNT;
                        end
                    end
                end
            end
        end
    end

    // R3: while a character is in progress the slot number stays in 1..OSR.
    a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HUNT) |-> (rt >= CNT_W'(1) && rt <= RT_END));

    // R3: a start check with a high majority abandons the character.
    a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == ST_START && rt_n == RT_V3 && vote) |=> (state == ST_HUNT));

    // R5: one character yields a single deliver pulse.
    a_r5_single_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> !deliver);

endmodule

// File: rtl/uart_rx_flags.sv
// Result holder: captures byte, noise and framing result on delivery and
// keeps the ready flag until cleared; delivery wins over a clear.
// Assumes: deliver and clr are one-cycle pulses.
module uart_rx_flags #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deliver,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              noise_in,
    input  logic              ferr_in,
    input  logic              clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_noise,
    output logic              rx_ferr
);
    // Load the character results on delivery; set or clear the ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_ready <= 1'b0;
            rx_noise <= 1'b0;
            rx_ferr  <= 1'b0;
        end else begin
            if (deliver) begin
                rx_data  <= byte_in;
                rx_noise <= noise_in;
                rx_ferr  <= ferr_in;
                rx_ready <= 1'b1;
            end else if (clr) begin
                rx_ready <= 1'b0;
            end
        end
    end

    // R8: a delivered character always raises the ready flag.
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        deliver |=> rx_ready);

    // R8: a clear strobe without delivery drops the flag.
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !deliver) |=> !rx_ready);

    // R10: results stay put between deliveries.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver |=> ($stable(rx_data) && $stable(rx_noise) && $stable(rx_ferr)));

endmodule

// File: rtl/uart_rx_qual.sv
// Top of the oversampled serial receiver: line watcher, character
// sequencer and result holder, with the interrupt gated by its enable.
// Assumes: rxd has been synchronised to clk upstream; rt_tick is one
// cycle wide at sixteen times the bit rate.
module uart_rx_qual #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rt_tick,
    input  logic              rxd,
    input  logic              irq_en,
    input  logic              clr_ready,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              rx_noise,
    output logic              rx_ferr,
    output logic              rx_irq
);
    localparam int AGE_W = $clog2(OSR + 1) + 1;

    logic              start_hit;
    logic [AGE_W-1:0]  edge_age_n;
    logic              deliver;
    logic [DATA_W-1:0] byte_q;
    logic              noise_q;
    logic              ferr_q;

    uart_rx_hunt #(.AGE_W(AGE_W)) u_hunt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (rt_tick),
        .rxd        (rxd),
        .start_hit  (start_hit),
        .edge_age_n (edge_age_n)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OSR(OSR), .AGE_W(AGE_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (rt_tick),
        .rxd        (rxd),
        .start_hit  (start_hit),
        .edge_age_n (edge_age_n),
        .deliver    (deliver),
        .byte_q     (byte_q),
        .noise_q    (noise_q),
        .ferr_q     (ferr_q)
    );

    uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .deliver  (deliver),
        .byte_in  (byte_q),
        .noise_in (noise_q),
        .ferr_in  (ferr_q),
        .clr      (clr_ready),
        .rx_data  (rx_data),
        .rx_ready (rx_ready),
        .rx_noise (rx_noise),
        .rx_ferr  (rx_ferr)
    );

    // Interrupt request follows the ready flag while enabled.
    always_comb rx_irq = rx_ready & irq_en;

    // R9: no request ever appears without a waiting byte.
    a_r9_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> rx_ready);

endmodule

// File: tb/uart_rx_qual_bench.sv
// Self-checking bench: stimulus tasks drive the line one tick sample at a
// time and advance a model of the ready flag; a monitor compares it with
// the design on every clock.
module uart_rx_qual_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rt_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       irq_en = 1'b0;
    logic       clr_ready = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, rx_noise, rx_ferr, rx_irq;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  exp_known = 1'b0;
    bit  exp_ready = 1'b0;
    bit  done = 1'b0;

    uart_rx_qual u_uart_rx_qual (
        .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rxd(rxd),
        .irq_en(irq_en), .clr_ready(clr_ready), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_noise(rx_noise), .rx_ferr(rx_ferr),
        .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One line sample: rxd set, three idle clocks, then one tick clock.
    task automatic put(input logic b, input logic c);
        rxd = b;
        repeat (3) @(negedge clk);
        rt_tick = 1'b1;
        clr_ready = c;
        @(negedge clk);
        rt_tick = 1'b0;
        clr_ready = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(1'b1, 1'b0);
    endtask

    // Accepted character; pat = start samples at slots 3,5,7 (MSB = slot 3).
    task automatic frame(input logic [7:0] d, input logic [2:0] pat, input logic stopv,
                         input int per, input logic clr_at_dec);
        logic v;
        if (per != 16) exp_known = 1'b0;
        for (int b = 0; b < 10; b++) begin
            for (int r = 1; r <= per; r++) begin
                v = (b == 0) ? 1'b0 : ((b == 9) ? stopv : d[b-1]);
                if (b == 0 && r == 3) v = pat[2];
                if (b == 0 && r == 5) v = pat[1];
                if (b == 0 && r == 7) v = pat[0];
                put(v, (per == 16 && b == 9 && r == 10) ? clr_at_dec : 1'b0);
                if (per == 16 && b == 9 && r == 10) exp_ready = 1'b1;
            end
        end
        if (per != 16) begin
            exp_ready = 1'b1;
            exp_known = 1'b1;
        end
    endtask

    // Rejected start: low first sample, then slot pairs set by pat.
    task automatic glitch(input logic [2:0] pat);
        put(1'b0, 1'b0);
        put(pat[2], 1'b0); put(pat[2], 1'b0);
        put(pat[1], 1'b0); put(pat[1], 1'b0);
        put(pat[0], 1'b0); put(pat[0], 1'b0);
        idle(9);
    endtask

    task automatic clear();
        clr_ready = 1'b1;
        @(negedge clk);
        clr_ready = 1'b0;
        exp_ready = 1'b0;
    endtask

    task automatic results(input string tag, input logic [7:0] d, input logic nz, input logic fe);
        check({tag, " data"}, 32'(rx_data), 32'(d));
        check({tag, " noise"}, 32'(rx_noise), 32'(nz));
        check({tag, " ferr"}, 32'(rx_ferr), 32'(fe));
        check({tag, " ready"}, 32'(rx_ready), 32'd1);
    endtask

    // Per-clock comparison against the ready model (R8) and irq rule (R9).
    always begin
        @(negedge clk);
        #1;
        if (rst_n && !done) begin
            if (exp_known) check("R8 ready model", 32'(rx_ready), 32'(exp_ready));
            check("R9 irq", 32'(rx_irq), 32'(rx_ready & irq_en));
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 data", 32'(rx_data), 32'h0);
        check("R1 ready", 32'(rx_ready), 32'h0);
        check("R1 noise", 32'(rx_noise), 32'h0);
        check("R1 ferr", 32'(rx_ferr), 32'h0);
        check("R1 irq", 32'(rx_irq), 32'h0);
        rst_n = 1'b1;
        exp_known = 1'b1;
        @(negedge clk);
        check("R1 ready after release", 32'(rx_ready), 32'h0);
        idle(5);

        // R5, R4: clean start, LSB-first byte.
        frame(8'h3C, 3'b000, 1'b1, 16, 1'b0);
        results("R5 clean 3C", 8'h3C, 1'b0, 1'b0);
        irq_en = 1'b1;
        @(negedge clk);
        check("R9 irq enabled", 32'(rx_irq), 32'd1);
        clear();
        check("R8 cleared", 32'(rx_ready), 32'd0);
        idle(2);

        // R4: the three noisy-but-accepted start patterns.
        frame(8'hA5, 3'b001, 1'b1, 16, 1'b0);
        results("R4 pat001", 8'hA5, 1'b1, 1'b0);
        clear();
        frame(8'h01, 3'b010, 1'b1, 16, 1'b0);
        results("R4 pat010", 8'h01, 1'b1, 1'b0);
        clear();
        frame(8'h80, 3'b100, 1'b1, 16, 1'b0);
        results("R4 pat100", 8'h80, 1'b1, 1'b0);
        // R10: next byte without clear replaces the noise flag.
        frame(8'hFF, 3'b000, 1'b1, 16, 1'b0);
        results("R10 noise replaced", 8'hFF, 1'b0, 1'b0);

        // R8: clear strobe in the delivery cycle; new byte wins.
        frame(8'h5A, 3'b000, 1'b1, 16, 1'b1);
        results("R8 collision", 8'h5A, 1'b0, 1'b0);
        clear();
        check("R8 lone clear", 32'(rx_ready), 32'd0);
        irq_en = 1'b0;
        idle(3);

        // R3: every rejecting start pattern delivers nothing.
        glitch(3'b011);
        glitch(3'b101);
        glitch(3'b110);
        glitch(3'b111);
        idle(200);
        check("R3 rejected starts", 32'(rx_ready), 32'd0);
        check("R3 data untouched", 32'(rx_data), 32'h5A);

        // R7: low stop bit flags a framing error but delivers.
        frame(8'hC3, 3'b000, 1'b0, 16, 1'b0);
        results("R7 ferr", 8'hC3, 1'b0, 1'b1);
        clear();

        // R2: a fall after only two high samples starts nothing.
        put(1'b1, 1'b0);
        put(1'b1, 1'b0);
        for (int i = 0; i < 170; i++) put(1'b0, 1'b0);
        idle(3);
        check("R2 no false start", 32'(rx_ready), 32'd0);
        check("R2 data untouched", 32'(rx_data), 32'hC3);
        frame(8'h96, 3'b000, 1'b1, 16, 1'b0);
        results("R2 start after three highs", 8'h96, 1'b0, 1'b0);
        clear();
        idle(4);

        // R6: sender slower and faster than the local bit timing.
        frame(8'h55, 3'b000, 1'b1, 18, 1'b0);
        idle(4);
        results("R6 slow 55", 8'h55, 1'b0, 1'b0);
        clear();
        frame(8'h33, 3'b000, 1'b1, 18, 1'b0);
        idle(4);
        results("R6 slow 33", 8'h33, 1'b0, 1'b0);
        clear();
        frame(8'h55, 3'b000, 1'b1, 14, 1'b0);
        idle(4);
        results("R6 fast 55", 8'h55, 1'b0, 1'b0);
        clear();
        idle(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule